// File: doc/BRIEF.md
# Sampling converter start-pin sequencer and serial reader

This block runs on the host side of a 10-bit serial sampling converter. The converter has one start pin, and that pin controls both its power and its conversions. The block raises and lowers that pin in the right order, waits out the converter's power-up and conversion times, and clocks the result in over a divided serial clock. A sample starts on a single-cycle request or on a tick from an internal period counter. The period counter sets the throughput: at a 50 MHz system clock, a period of 5000 cycles gives 10 kSPS.

The block has two operating styles, chosen by `mode_hs`. In high-speed style (`mode_hs` = 1) the start pin rests high, so the converter stays powered. Each conversion is then a short low pulse, and the pin is raised again well before the conversion finishes. In low-power style (`mode_hs` = 0) the pin rests low, so the converter sleeps between samples. A sample then begins with a wake-up pulse that lasts at least the power-up time. The falling edge of that pulse starts the conversion, and the pin is left low afterwards so the converter powers down by itself. The read always starts once the conversion time has elapsed, so the data returned belongs to the conversion just started.

Results leave on a valid/ready stream. `res_valid` rises together with a new word and stays high, with `res_data` unchanged, until a cycle in which `res_ready` is high. While a result waits, the block counts as busy and starts no new sample. This is how back-pressure slows sampling down. With `res_ready` tied high, `res_valid` is a one-cycle strobe.

Top module: `adc_sample_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `cnv_start`, `adc_sclk`, `res_valid` and `busy` are all low.
- R2: In low-power style (`mode_hs`=0), a trigger raises `cnv_start` at the triggering edge. The pin stays high for exactly PWRUP_CYC cycles, then falls to start the conversion.
- R3: In high-speed style (`mode_hs`=1), `cnv_start` rests high when idle. If the pin has already been high for at least PWRUP_CYC cycles, it falls at the triggering edge. It rises again LOW_CYC cycles later, which is before the conversion time ends.
- R4: In low-power style, `cnv_start` stays low from its falling edge until the result is delivered, and it stays low at idle.
- R5: The serial read begins CONV_CYC cycles after the falling edge of `cnv_start`. `adc_sclk` rests low and toggles every SCLK_HALF cycles, giving exactly 10 rising edges per read.
- R6: `adc_dout` is sampled at each rising edge of `adc_sclk`, and the first bit received is the most significant bit of `res_data`.
- R7: `res_valid` rises at the edge of the last falling `adc_sclk` edge. While `res_ready` is low, `res_valid` stays high and `res_data` stays stable. The word is taken and `res_valid` drops at the first edge where `res_ready` is high.
- R8: `busy` is high from the triggering edge until the result is taken. A request or tick that arrives while `busy` is high is ignored.
- R9: With `auto_en` high, a trigger is generated every `period_cfg` cycles, where a value of 0 acts as 1. Ticks that fall while busy are lost.
- R10: In high-speed style, if the pin has been high for fewer than PWRUP_CYC cycles, for example just after a switch from low-power style, the fall is delayed until the pin has been high for PWRUP_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_hs | input | 1 | 1 = high-speed style (pin rests high), 0 = low-power style |
| sample_req | input | 1 | Single-cycle request for one sample |
| auto_en | input | 1 | Enables the periodic trigger |
| period_cfg | input | PERIOD_W | Sample period in system clock cycles |
| cnv_start | output | 1 | Converter start/power pin |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_dout | input | 1 | Serial data from the converter |
| busy | output | 1 | A sample is in progress or its result is waiting |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 10 | Converted word |

## Verification
Every output has a fixed cycle offset from the triggering edge. In low-power style the pin falls PWRUP_CYC cycles after the trigger. The first `adc_sclk` rise comes CONV_CYC+SCLK_HALF cycles after the fall, and `res_valid` appears CONV_CYC+20·SCLK_HALF cycles after the fall. In high-speed style, when the pin is already warm, the fall happens at the trigger edge itself. A reference model in the bench computes each of these edges from the trigger cycle, using arithmetic on cycle counts. All outputs are compared with the model at every falling clock edge, when the registered outputs have settled. Directed latency measurements from the request to `res_valid` add exact end-to-end counts for the low-power, warm high-speed and cold high-speed cases.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAKE,
    SQ_CONV,
    SQ_READ,
    SQ_DONE
  } seq_state_t;
endpackage

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                auto_en,
  input  logic [PERIOD_W-1:0] period_cfg,
  output logic                tick
);
  logic [PERIOD_W-1:0] tcnt;
  logic [PERIOD_W-1:0] lim_m1;

  // A period of zero behaves like a period of one.
  assign lim_m1 = (period_cfg == '0) ? '0 : period_cfg - 1'b1;
  assign tick   = auto_en && (tcnt >= lim_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
    end else if (!auto_en || tick) begin
      tcnt <= '0;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  // R9: with a stable period above one, ticks are never back to back
  a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick) && auto_en && $stable(period_cfg) && (period_cfg > 1) |-> !tick);
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned PWRUP_CYC = 75,
  parameter int unsigned CONV_CYC  = 115,
  parameter int unsigned LOW_CYC   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_hs,
  input  logic trig,
  input  logic rd_done,
  input  logic res_taken,
  output logic pin,
  output logic rd_go,
  output logic busy
);
  localparam int unsigned WARM_W = $clog2(PWRUP_CYC + 1);
  localparam int unsigned CNT_W  = $clog2(CONV_CYC + 1);
  localparam logic [WARM_W-1:0] WARM_MIN  = WARM_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0]  CONV_LAST = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0]  LOW_LIM   = CNT_W'(LOW_CYC);

  seq_state_t        state, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [WARM_W-1:0] warm;
  logic              pin_q, pin_n;
  logic              hs_q, hs_n;
  logic              warm_ok;

  // Pin has been high for at least the power-up time at this edge.
  assign warm_ok = pin_q && (warm >= WARM_MIN);

  always_comb begin
    st_n  = state;
    cnt_n = cnt;
    hs_n  = hs_q;
    case (state)
      SQ_IDLE: begin
        if (trig) begin
          hs_n = mode_hs;
          if (warm_ok) begin
            st_n  = SQ_CONV;
            cnt_n = '0;
          end else begin
            st_n = SQ_WAKE;
          end
        end
      end
      SQ_WAKE: begin
        if (warm_ok) begin
          st_n  = SQ_CONV;
          cnt_n = '0;
        end
      end
      SQ_CONV: begin
        if (cnt == CONV_LAST) begin
          st_n = SQ_READ;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      SQ_READ: begin
        if (rd_done) st_n = SQ_DONE;
      end
      SQ_DONE: begin
        if (res_taken) st_n = SQ_IDLE;
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  // Pin level is chosen from the state being entered.
  always_comb begin
    case (st_n)
      SQ_WAKE: pin_n = 1'b1;
      SQ_CONV: pin_n = hs_n && (cnt_n >= LOW_LIM);
      SQ_READ: pin_n = hs_n;
      default: pin_n = mode_hs;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
      pin_q <= 1'b0;
      hs_q  <= 1'b0;
      warm  <= '0;
    end else begin
      state <= st_n;
      cnt   <= cnt_n;
      pin_q <= pin_n;
      hs_q  <= hs_n;
      if (!pin_q)               warm <= '0;
      else if (warm < WARM_MIN) warm <= warm + 1'b1;
    end
  end

  assign pin   = pin_q;
  assign rd_go = (state == SQ_CONV) && (cnt == CONV_LAST);
  assign busy  = (state != SQ_IDLE);

  // R2: a conversion-starting fall only follows a full power-up interval
  a_r2_fall_after_warm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_q) && (state == SQ_CONV) |-> ($past(warm) >= WARM_MIN));
  // R3: in high-speed style the pin is back high when the read is launched
  a_r3_raised_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && hs_q |-> pin_q);
  // R4: in low-power style the pin stays low while converting and reading
  a_r4_low_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == SQ_CONV) || (state == SQ_READ)) && !hs_q |-> !pin_q);
  // R8: a finished sample waits for the taker before idling
  a_r8_done_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_DONE) && !res_taken |=> (state == SQ_DONE));
endmodule

// File: rtl/adc_shift_rx.sv
module adc_shift_rx #(
  parameter int unsigned RES_W     = 10,
  parameter int unsigned SCLK_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sdata,
  output logic             sclk,
  output logic             done,
  output logic [RES_W-1:0] word
);
  localparam int unsigned DIV_W = $clog2(SCLK_HALF + 1);
  localparam int unsigned NB_W  = $clog2(RES_W + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_HALF - 1);
  localparam logic [NB_W-1:0]  NB_FULL  = NB_W'(RES_W);

  logic             active;
  logic [DIV_W-1:0] div;
  logic             sclk_q;
  logic [NB_W-1:0]  nbit;
  logic [RES_W-1:0] shreg;
  logic             tog;

  assign tog  = active && (div == DIV_LAST);
  assign done = tog && sclk_q && (nbit == NB_FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      div    <= '0;
      sclk_q <= 1'b0;
      nbit   <= '0;
      shreg  <= '0;
    end else if (start) begin
      active <= 1'b1;
      div    <= '0;
      sclk_q <= 1'b0;
      nbit   <= '0;
    end else if (active) begin
      if (tog) begin
        div <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          shreg  <= {shreg[RES_W-2:0], sdata};
          nbit   <= nbit + 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (done) active <= 1'b0;
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  assign sclk = sclk_q;
  assign word = shreg;

  // R6: never more bits captured than the word holds
  a_r6_bits_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    nbit <= NB_FULL);
  // R5: the serial clock is parked low after the last bit
  a_r5_sclk_parks_low: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !sclk_q && !active);
endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] word,
  input  logic             ready,
  output logic             valid,
  output logic [RES_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= word;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R7: an unaccepted result holds both flag and word
  a_r7_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data));
endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl #(
  parameter int unsigned RES_W     = 10,
  parameter int unsigned PERIOD_W  = 16,
  parameter int unsigned PWRUP_CYC = 75,
  parameter int unsigned CONV_CYC  = 115,
  parameter int unsigned LOW_CYC   = 10,
  parameter int unsigned SCLK_HALF = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_hs,
  input  logic                sample_req,
  input  logic                auto_en,
  input  logic [PERIOD_W-1:0] period_cfg,
  output logic                cnv_start,
  output logic                adc_sclk,
  input  logic                adc_dout,
  output logic                busy,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [RES_W-1:0]    res_data
);
  logic             tick;
  logic             trig;
  logic             rd_go;
  logic             rd_done;
  logic [RES_W-1:0] rd_word;

  assign trig = sample_req | tick;

  adc_rate_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en),
    .period_cfg(period_cfg), .tick(tick)
  );

  adc_start_seq #(
    .PWRUP_CYC(PWRUP_CYC), .CONV_CYC(CONV_CYC), .LOW_CYC(LOW_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_hs(mode_hs), .trig(trig),
    .rd_done(rd_done), .res_taken(res_valid && res_ready),
    .pin(cnv_start), .rd_go(rd_go), .busy(busy)
  );

  adc_shift_rx #(.RES_W(RES_W), .SCLK_HALF(SCLK_HALF)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(rd_go), .sdata(adc_dout),
    .sclk(adc_sclk), .done(rd_done), .word(rd_word)
  );

  adc_result_buf #(.RES_W(RES_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(rd_done), .word(rd_word),
    .ready(res_ready), .valid(res_valid), .data(res_data)
  );

  // R8: a result is only on offer while the block reports busy
  a_r8_valid_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);
  // R1: reset leaves the pin low on the next edge
  a_r1_pin_low_from_reset: assert property (@(posedge clk)
    !rst_n |=> !cnv_start && !res_valid);
endmodule

// File: tb/adc_sample_ctrl_test.sv
module adc_sample_ctrl_test;
  localparam int P = 75, C = 115, LW = 10, H = 2, RW = 10;

  logic clk = 0, rst_n = 0;
  logic mode_hs = 0, sample_req = 0, auto_en = 0, res_ready = 1;
  logic [15:0] period_cfg = 16'd0;
  logic cnv_start, adc_sclk, adc_dout, busy, res_valid;
  logic [RW-1:0] res_data;

  always #10 clk = ~clk;

  adc_sample_ctrl #(.RES_W(RW), .PERIOD_W(16), .PWRUP_CYC(P), .CONV_CYC(C),
                    .LOW_CYC(LW), .SCLK_HALF(H)) uut (
    .clk(clk), .rst_n(rst_n), .mode_hs(mode_hs), .sample_req(sample_req),
    .auto_en(auto_en), .period_cfg(period_cfg), .cnv_start(cnv_start),
    .adc_sclk(adc_sclk), .adc_dout(adc_dout), .busy(busy),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  // Converter stand-in: latches a word on each start-pin fall, shifts MSB first
  logic [RW-1:0] conv_val = 10'h2A5, adc_cur = '0;
  int bidx = 0;
  always @(negedge cnv_start) begin
    adc_cur = conv_val;
    bidx = 0;
    conv_val = {conv_val[RW-2:0], conv_val[RW-1] ^ conv_val[6]};
  end
  always @(negedge adc_sclk) bidx = bidx + 1;
  always_comb adc_dout = (bidx < RW) ? adc_cur[RW-1-bidx] : 1'b0;

  // Behavioural reference: deadlines counted from the trigger edge
  int n, rise, tf, st, tk, d, lim;
  bit epin, npin, hs, tick, esclk, ev;
  logic [RW-1:0] ed;
  int m_taken, d_taken;
  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; rise = 0; tf = 0; st = 0; tk = 0;
      epin = 0; hs = 0; esclk = 0; ev = 0; ed = '0;
    end else begin
      n++;
      lim  = (period_cfg == 0) ? 1 : int'(period_cfg);
      tick = auto_en && (tk == lim - 1);
      tk   = (!auto_en || tick) ? 0 : tk + 1;
      npin = epin;
      esclk = 0;
      if (ev && res_ready) m_taken++;
      case (st)
        0: if (sample_req || tick) begin
             hs = mode_hs;
             if (epin && (n - rise >= P)) begin st = 2; tf = n; npin = 0; end
             else begin st = 1; npin = 1; end
           end else npin = mode_hs;
        1: if (n - rise >= P) begin st = 2; tf = n; npin = 0; end
           else npin = 1;
        2: begin
             d = n - tf;
             if (d == C + 20 * H) begin
               st = 3; ev = 1; ed = adc_cur; npin = mode_hs;
             end else begin
               npin  = (d < C) ? (hs && d >= LW) : hs;
               esclk = (d >= C) && (((d - C) / H) % 2 == 1);
             end
           end
        default: begin
             if (res_ready) begin st = 0; ev = 0; end
             npin = mode_hs;
           end
      endcase
      if (npin && !epin) rise = n;
      epin = npin;
    end
  end

  int checks = 0, fails = 0, cyc = 0;
  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // Compare every output with the model away from the active edge
  always @(negedge clk) begin
    string pt;
    cyc++;
    if (!rst_n) pt = "R1";
    else if (st == 1 && hs) pt = "R10";
    else if (st == 0 || st == 3) pt = mode_hs ? "R3" : "R4";
    else if (!hs && st == 2) pt = "R4";
    else pt = hs ? "R3" : "R2";
    if (rst_n && !res_valid && res_ready) d_taken = d_taken;
    if (res_valid && res_ready) d_taken++;
    chk(pt, "cnv_start", int'(cnv_start), int'(epin));
    chk(rst_n ? "R5" : "R1", "adc_sclk", int'(adc_sclk), int'(esclk));
    chk(rst_n ? "R7" : "R1", "res_valid", int'(res_valid), int'(ev));
    chk(rst_n ? "R8" : "R1", "busy", int'(busy), int'(st != 0));
    if (ev) chk("R6", "res_data", int'(res_data), int'(ed));
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  task automatic lat_sample(output int lat);
    sample_req = 1;
    @(negedge clk);
    sample_req = 0;
    lat = 1;
    while (!res_valid && lat < 5000) begin @(negedge clk); lat++; end
  endtask

  initial begin
    int lat;
    m_taken = 0; d_taken = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);

    // R2/R4: low-power sample, end-to-end latency includes power-up
    lat_sample(lat);
    chk("R2", "low-power latency", lat, P + C + 20 * H + 1);
    repeat (5) @(negedge clk);

    // R8: a second request during a sample is dropped
    sample_req = 1; @(negedge clk); sample_req = 0;
    repeat (60) @(negedge clk);
    sample_req = 1; @(negedge clk); sample_req = 0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R8", "busy after ignored request", int'(busy), 0);

    // R7: back-pressure holds the word
    res_ready = 0;
    lat_sample(lat);
    repeat (25) @(negedge clk);
    chk("R7", "valid held", int'(res_valid), 1);
    res_ready = 1;
    @(negedge clk);
    chk("R7", "valid dropped after take", int'(res_valid), 0);
    repeat (3) @(negedge clk);

    // R10: switch to high-speed and request at once: pin is cold
    mode_hs = 1;
    lat_sample(lat);
    chk("R10", "cold high-speed latency", lat, P + C + 20 * H + 1);
    repeat (P + 5) @(negedge clk);

    // R3: warm pin falls at the trigger edge
    lat_sample(lat);
    chk("R3", "warm high-speed latency", lat, C + 20 * H + 1);
    repeat (3) @(negedge clk);

    // R9: periodic triggering in both styles and with period zero
    m_taken = 0; d_taken = 0;
    period_cfg = 16'd200; auto_en = 1;
    repeat (2000) @(negedge clk);
    auto_en = 0; wait_idle();
    mode_hs = 0; period_cfg = 16'd300; auto_en = 1;
    repeat (2000) @(negedge clk);
    auto_en = 0; wait_idle();
    period_cfg = 16'd0; auto_en = 1;
    repeat (1200) @(negedge clk);
    auto_en = 0; wait_idle();
    repeat (3) @(negedge clk);
    chk("R9", "results delivered in periodic runs", d_taken, m_taken);
    chk("R9", "periodic runs produced results", int'(d_taken > 10), 1);

    // R1: reset mid-sample clears everything
    sample_req = 1; @(negedge clk); sample_req = 0;
    repeat (30) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1", "pin in reset", int'(cnv_start), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule